// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block holds eight single-bit hardware semaphores. They are kept apart from any data storage and are shared between a left port and a right port. Software on either side uses them to reserve a shared resource.

A port asks for a semaphore by writing 0 and gives it back by writing 1. Only data bit 0 of a write is used. A read returns 0 to the side that holds the token and 1 to every other reader.

If one side asks for a semaphore while the other side holds it, the request is kept. Ownership then passes to the asking side in the same edge that the holder releases. When both sides ask for a free semaphore in the same cycle, the left side gets the token and the right side's request is kept as pending.

The read result goes into an output register. A write made on the other port in the same cycle therefore cannot change the value being read.

Each port reaches the bank when its semaphore select is low and its memory chip enable is high. All state changes take place on the rising clock edge.

Top module: `dual_sem_bank`

## Requirements
- R1: After reset all eight semaphores are free with no pending requests, and both data outputs read all ones.
- R2: A port reaches the bank only while `x_sem_n` is 0 and `x_mem_ce_n` is 1. Any other combination leaves the semaphores and that port's data output unchanged. Only address bits [2:0] choose the semaphore, and the upper address bits are ignored.
- R3: A write (`x_wr_n`=0) of `x_d0`=0 to a free semaphore gives the token to the writing side. That side then reads 0 and the other side reads 1.
- R4: While one side holds a semaphore, writes from the other side never change who holds it.
- R5: If the non-holding side wrote 0 while the holder owned the token, ownership passes to it in the same edge that the holder writes 1.
- R6: When the holder writes 1 and no request is pending, the semaphore becomes free and both sides read 1.
- R7: A write of 1 by a side that has only a pending request, and does not hold the token, cancels that request.
- R8: When both sides write 0 in the same cycle to the same free semaphore, the left side wins and the right side's request stays pending.
- R9: A read (`x_wr_n`=1, `x_oe_n`=0) loads the semaphore value onto every line of the port's data output at the edge. The output then holds that value until the port's next read.
- R10: A read returns the value that held before the edge, even when the other port writes the same semaphore in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_mem_ce_n | input | 1 | Left memory chip enable, must be 1 for semaphore access |
| l_wr_n | input | 1 | Left write strobe, 0 = write, 1 = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | AW | Left address, bits [2:0] select the semaphore |
| l_d0 | input | 1 | Left write data bit 0 |
| l_q | output | DW | Left registered read data |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_mem_ce_n | input | 1 | Right memory chip enable, must be 1 for semaphore access |
| r_wr_n | input | 1 | Right write strobe, 0 = write, 1 = read |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | AW | Right address, bits [2:0] select the semaphore |
| r_d0 | input | 1 | Right write data bit 0 |
| r_q | output | DW | Right registered read data |

## Verification
A write changes a semaphore at the rising edge of the cycle in which it is presented. A read presented in any later cycle sees that change. Read data is loaded at the edge of the read cycle, so the bench drives inputs at the falling edge and checks `l_q` and `r_q` at the next falling edge, one edge after the read. After every write-only cycle the bench also confirms that both outputs still hold the last read values. For the snapshot case, a write and a read on opposite ports share one cycle, and the result is compared with the value from before that edge.

// File: rtl/dual_sem_bank.sv
module dual_sem_bank #(
  parameter int NSEM = 8,
  parameter int AW   = 14,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sem_n,
  input  logic          l_mem_ce_n,
  input  logic          l_wr_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic          l_d0,
  output logic [DW-1:0] l_q,
  input  logic          r_sem_n,
  input  logic          r_mem_ce_n,
  input  logic          r_wr_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic          r_d0,
  output logic [DW-1:0] r_q
);
  localparam int SW = $clog2(NSEM);

  logic [NSEM-1:0] lreq, rreq, rtok;
  logic [NSEM-1:0] l_own, r_own;

  wire l_acc = !l_sem_n && l_mem_ce_n;
  wire r_acc = !r_sem_n && r_mem_ce_n;
  wire l_wr  = l_acc && !l_wr_n;
  wire r_wr  = r_acc && !r_wr_n;
  wire l_rd  = l_acc && l_wr_n && !l_oe_n;
  wire r_rd  = r_acc && r_wr_n && !r_oe_n;
  wire [SW-1:0] la = l_addr[SW-1:0];
  wire [SW-1:0] ra = r_addr[SW-1:0];

  assign l_own = lreq & ~(rreq & rtok);
  assign r_own = rreq & ~(lreq & ~rtok);

  for (genvar i = 0; i < NSEM; i++) begin : g_sem
    wire hit_l = l_wr && (la == SW'(i));
    wire hit_r = r_wr && (ra == SW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lreq[i] <= 1'b0;
        rreq[i] <= 1'b0;
        rtok[i] <= 1'b0;
      end else begin
        if (hit_l) lreq[i] <= !l_d0;
        if (hit_r) rreq[i] <= !r_d0;
        rtok[i] <= (lreq[i] && rreq[i]) ? rtok[i] : (rreq[i] && !lreq[i]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_q <= '1;
      r_q <= '1;
    end else begin
      if (l_rd) l_q <= {DW{!l_own[la]}};
      if (r_rd) r_q <= {DW{!r_own[ra]}};
    end
  end
endmodule

module dual_sem_bank_chk #(
  parameter int NSEM = 8,
  parameter int AW   = 14,
  parameter int DW   = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l_sem_n,
  input logic          l_mem_ce_n,
  input logic          l_wr_n,
  input logic          l_oe_n,
  input logic [AW-1:0] l_addr,
  input logic          l_d0,
  input logic [DW-1:0] l_q,
  input logic          r_sem_n,
  input logic          r_mem_ce_n,
  input logic          r_wr_n,
  input logic          r_oe_n,
  input logic [AW-1:0] r_addr,
  input logic          r_d0,
  input logic [DW-1:0] r_q,
  input logic [NSEM-1:0] l_own,
  input logic [NSEM-1:0] r_own
);
  localparam int SW = $clog2(NSEM);
  wire l_acc = !l_sem_n && l_mem_ce_n;
  wire r_acc = !r_sem_n && r_mem_ce_n;
  wire l_wr  = l_acc && !l_wr_n;
  wire r_wr  = r_acc && !r_wr_n;
  wire l_rd  = l_acc && l_wr_n && !l_oe_n;
  wire r_rd  = r_acc && r_wr_n && !r_oe_n;
  wire [SW-1:0] la = l_addr[SW-1:0];
  wire [SW-1:0] ra = r_addr[SW-1:0];

  // R2
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_acc && !r_acc) |=> ($stable(l_own) && $stable(r_own)));
  // R3
  left_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && !l_d0 && !r_own[la]) |=> l_own[$past(la)]);
  // R4
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wr && l_own[ra] && !(l_wr && la == ra)) |=> l_own[$past(ra)]);
  // R9
  all_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_q == '0 || l_q == '1) && (r_q == '0 || r_q == '1));
  // R9
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> $stable(l_q));
  // R10
  rd_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_rd |=> (r_q[0] == !$past(r_own[ra])));
endmodule

bind dual_sem_bank dual_sem_bank_chk #(.NSEM(NSEM), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sem_n(l_sem_n), .l_mem_ce_n(l_mem_ce_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n),
  .l_addr(l_addr), .l_d0(l_d0), .l_q(l_q),
  .r_sem_n(r_sem_n), .r_mem_ce_n(r_mem_ce_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n),
  .r_addr(r_addr), .r_d0(r_d0), .r_q(r_q),
  .l_own(l_own), .r_own(r_own)
);

// File: tb/dual_sem_bank_tb.sv
module dual_sem_bank_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_sem_n = 1'b1, l_mem_ce_n = 1'b1, l_wr_n = 1'b1, l_oe_n = 1'b1, l_d0 = 1'b1;
  logic r_sem_n = 1'b1, r_mem_ce_n = 1'b1, r_wr_n = 1'b1, r_oe_n = 1'b1, r_d0 = 1'b1;
  logic [13:0] l_addr = '0, r_addr = '0;
  logic [15:0] l_q, r_q;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;
  int mo[8];
  int mp[8];
  logic [15:0] last_l, last_r;

  always #2 clk = ~clk;

  dual_sem_bank u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_sem_n(l_sem_n), .l_mem_ce_n(l_mem_ce_n), .l_wr_n(l_wr_n), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_d0(l_d0), .l_q(l_q),
    .r_sem_n(r_sem_n), .r_mem_ce_n(r_mem_ce_n), .r_wr_n(r_wr_n), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_d0(r_d0), .r_q(r_q)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sem_n = 1'b1; l_mem_ce_n = 1'b1; l_wr_n = 1'b1; l_oe_n = 1'b1; l_d0 = 1'b1;
    r_sem_n = 1'b1; r_mem_ce_n = 1'b1; r_wr_n = 1'b1; r_oe_n = 1'b1; r_d0 = 1'b1;
  endtask

  function automatic logic [13:0] addr_of(input int s);
    logic [13:0] a;
    a = 14'($urandom);
    a[2:0] = 3'(s);
    return a;
  endfunction

  function automatic string apply(input int lop, input int rop, input int s);
    string tag;
    bit nl, nr;
    int no, np;
    if (mo[s] == 0 && lop == 1 && rop == 1) tag = "R8";
    else if ((mo[s] == 1 && lop == 2 && mp[s] == 2) || (mo[s] == 2 && rop == 2 && mp[s] == 1)) tag = "R5";
    else if ((mo[s] == 1 && lop == 2) || (mo[s] == 2 && rop == 2)) tag = "R6";
    else if ((mp[s] == 1 && lop == 2) || (mp[s] == 2 && rop == 2)) tag = "R7";
    else if ((mo[s] == 1 && rop != 0) || (mo[s] == 2 && lop != 0)) tag = "R4";
    else tag = "R3";
    nl = (mo[s] == 1) || (mp[s] == 1);
    nr = (mo[s] == 2) || (mp[s] == 2);
    if (lop == 1) nl = 1'b1;
    if (lop == 2) nl = 1'b0;
    if (rop == 1) nr = 1'b1;
    if (rop == 2) nr = 1'b0;
    if (mo[s] == 1 && nl) no = 1;
    else if (mo[s] == 2 && nr) no = 2;
    else if (nl) no = 1;
    else if (nr) no = 2;
    else no = 0;
    np = (no == 1 && nr) ? 2 : (no == 2 && nl) ? 1 : 0;
    mo[s] = no;
    mp[s] = np;
    return tag;
  endfunction

  // ops: 0 idle, 1 write 0 (request), 2 write 1 (release)
  task automatic step(input int lop, input int rop, input int s, output string tag);
    if (lop != 0) begin
      l_sem_n = 1'b0; l_wr_n = 1'b0; l_addr = addr_of(s); l_d0 = (lop == 2);
    end
    if (rop != 0) begin
      r_sem_n = 1'b0; r_wr_n = 1'b0; r_addr = addr_of(s); r_d0 = (rop == 2);
    end
    @(posedge clk);
    @(negedge clk);
    idle();
    tag = apply(lop, rop, s);
  endtask

  task automatic rd_both(input int s);
    l_sem_n = 1'b0; l_oe_n = 1'b0; l_addr = addr_of(s);
    r_sem_n = 1'b0; r_oe_n = 1'b0; r_addr = addr_of(s);
    @(posedge clk);
    @(negedge clk);
    idle();
    last_l = l_q;
    last_r = r_q;
  endtask

  function automatic logic [15:0] exp_l(input int s);
    return (mo[s] == 1) ? 16'h0000 : 16'hFFFF;
  endfunction
  function automatic logic [15:0] exp_r(input int s);
    return (mo[s] == 2) ? 16'h0000 : 16'hFFFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      misses++;
      vectors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    string tag;
    logic [15:0] keep;
    for (int i = 0; i < 8; i++) begin mo[i] = 0; mp[i] = 0; end
    idle();
    repeat (3) @(negedge clk);
    // R1: outputs at reset
    chk(l_q == 16'hFFFF && r_q == 16'hFFFF, "R1", l_q ^ ~r_q, 16'hFFFF);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      rd_both(s);
      chk(l_q == 16'hFFFF, "R1", l_q, 16'hFFFF);
      chk(r_q == 16'hFFFF, "R1", r_q, 16'hFFFF);
    end

    // R2: write with select high is ignored
    l_sem_n = 1'b1; l_wr_n = 1'b0; l_d0 = 1'b0; l_addr = addr_of(3);
    @(posedge clk); @(negedge clk); idle();
    // R2: write with memory enable active is ignored
    r_sem_n = 1'b0; r_mem_ce_n = 1'b0; r_wr_n = 1'b0; r_d0 = 1'b0; r_addr = addr_of(3);
    @(posedge clk); @(negedge clk); idle();
    rd_both(3);
    chk(l_q == 16'hFFFF, "R2", l_q, 16'hFFFF);
    chk(r_q == 16'hFFFF, "R2", r_q, 16'hFFFF);

    // R2: read blocked keeps the output
    step(1, 0, 1, tag);
    rd_both(1);
    chk(l_q == 16'h0000, "R3", l_q, 16'h0000);
    l_sem_n = 1'b1; l_oe_n = 1'b0; l_addr = addr_of(2);
    @(posedge clk); @(negedge clk); idle();
    chk(l_q == 16'h0000, "R2", l_q, 16'h0000);
    l_sem_n = 1'b0; l_mem_ce_n = 1'b0; l_oe_n = 1'b0; l_addr = addr_of(2);
    @(posedge clk); @(negedge clk); idle();
    chk(l_q == 16'h0000, "R2", l_q, 16'h0000);
    step(2, 0, 1, tag);

    // R10: right reads while left releases with right pending
    step(1, 0, 5, tag);
    step(0, 1, 5, tag);
    r_sem_n = 1'b0; r_oe_n = 1'b0; r_addr = addr_of(5);
    l_sem_n = 1'b0; l_wr_n = 1'b0; l_d0 = 1'b1; l_addr = addr_of(5);
    @(posedge clk); @(negedge clk); idle();
    tag = apply(2, 0, 5);
    chk(r_q == 16'hFFFF, "R10", r_q, 16'hFFFF);
    rd_both(5);
    chk(r_q == 16'h0000, "R5", r_q, 16'h0000);
    chk(l_q == 16'hFFFF, "R5", l_q, 16'hFFFF);
    step(0, 2, 5, tag);

    // Sweep: every 3-step pair sequence on every semaphore
    for (int s = 0; s < 8; s++) begin
      for (int seq = 0; seq < 729; seq++) begin
        int code;
        step(2, 2, s, tag);
        code = seq;
        for (int k = 0; k < 3; k++) begin
          int pr;
          pr = code % 9;
          code = code / 9;
          keep = last_l;
          step(pr % 3, pr / 3, s, tag);
          // R9: outputs hold through non-read cycles
          chk(l_q == keep && r_q == last_r, "R9", l_q, keep);
          rd_both(s);
          chk(l_q == exp_l(s), tag, l_q, exp_l(s));
          chk(r_q == exp_r(s), tag, r_q, exp_r(s));
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule